// File: doc/BRIEF.md
# Control Mode Sequencer with Hardware Logout

This block holds the processor's control-status flags: the sequence-counter mode, the main-store mode, the control-store mode and a log flag. Exactly one of the three mode flags names the controller that currently drives the shared data paths. This is ownership, not arbitration, so no controller is ever queued behind another. The block changes ownership with a fixed protocol. An interrupt condition first raises clock-stop requests. Then comes one dead cycle, in which the gated register pulses are suppressed and a gate-status strobe rewrites the flags. Finally the stop latches that the new owner needs are released.

The protocol is used here for the error logout. A logout request stops the processor/I-O, control-store and main-store clocks, and the dead cycle turns on the log flag and the sequence-counter mode. The block then issues store commands for the storage data, storage address and instruction address registers. Next it hands control to main store, which logs the four control-store data groups and the control-store address register, and frees the control-store clock. Two machine cycles later control returns to the control store and all stop latches clear. Machine cycles are marked by the free-running `tick` input. Each store command completes with a `store_done` strobe. The clock-stop unit itself, the storage timing and the register datapath lie outside the block.

Top module: `ctl_mode_sequencer`

## Requirements
- R1: After synchronous reset the flags read mode_cs=1, mode_seq=0, mode_ms=0 and log_flag=0, and stop_set, stop_clr, gate_status, dead_cycle and cmd_valid are all 0.
- R2: In the idle state, a cycle with logout_req=1 and tick=1 drives stop_set=4'b0111 for that cycle. The stop bits are: bit0 processor/I-O, bit1 control store, bit2 main store, bit3 storage holdoff. Without tick, the request has no effect.
- R3: After the stop request comes exactly one dead cycle. It holds dead_cycle=1 until the next tick. On that tick, gate_status=1 and stop_clr=4'b0100 (main-store stop released) in the same cycle.
- R4: From the cycle after the dead cycle's tick, log_flag=1 and mode_seq=1.
- R5: Store commands use cmd_src as the order index and cmd_addr = 80 + 4*cmd_src. They are issued in this order: 0 storage data, 1 storage address, 2 instruction address, 3..6 control-store data groups 1..4, 7 control-store address. Each command holds cmd_valid=1 with a stable address until store_done.
- R6: After source 2 is accepted, the block waits for one tick. The mode then becomes mode_ms=1 with mode_seq=0.
- R7: In the cycle that source 7 is accepted, stop_clr=4'b0010 (control-store stop released).
- R8: The next tick sets mode_cs=1. The tick after that drives stop_clr=4'b1111 and clears log_flag, and the block returns to idle.
- R9: At most one of mode_seq, mode_ms and mode_cs is 1 at any time.
- R10: store_done has no effect while cmd_valid=0, and logout_req has no effect while a logout is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Free-running machine-cycle pulse |
| logout_req | input | 1 | Error interrupt requesting a logout |
| store_done | input | 1 | Completion strobe for the pending store command |
| stop_set | output | 4 | Set requests to the clock-stop latches |
| stop_clr | output | 4 | Clear requests to the clock-stop latches |
| dead_cycle | output | 1 | Gated register pulses are suppressed |
| gate_status | output | 1 | Strobe that rewrites the control-status flags |
| mode_seq | output | 1 | Sequence counter owns the data paths |
| mode_ms | output | 1 | Main store owns the data paths |
| mode_cs | output | 1 | Control store owns the data paths |
| log_flag | output | 1 | Logout in progress |
| cmd_valid | output | 1 | A store command is pending |
| cmd_addr | output | 16 | Target address of the pending store |
| cmd_src | output | 3 | Register selected for the pending store |

## Verification
The logout is run twice. The first run has a tick and a completion on every cycle, which exposes any extra or missing state in the sequence. The second run has idle cycles before every tick and every completion, which separates steps that wait for tick from steps that wait for store_done. It also shows whether the dead cycle really lasts until a tick. A scoreboard compares every accepted store against the expected address and source order. Stray requests and stray completions are injected at points where they must be ignored, and a request without tick is tried in idle.

// File: rtl/ctl_sv_pkg.sv
package ctl_sv_pkg;

    localparam int STOP_W = 4;

    // Clock-stop latch positions shared with the clock-stop unit
    localparam int STOP_CPUIO   = 0;
    localparam int STOP_CSTORE  = 1;
    localparam int STOP_MSTORE  = 2;
    localparam int STOP_HOLDOFF = 3;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DEAD,
        SQ_SAVE_SC,
        SQ_TO_MS,
        SQ_SAVE_MS,
        SQ_TO_CS,
        SQ_RELEASE
    } seq_state_t;

    typedef struct packed {
        logic intr;     // interrupt: raise stop latches
        logic gate;     // dead-cycle gate-status strobe
        logic to_ms;    // hand ownership to main store
        logic cs_free;  // control-store clock may run again
        logic to_cs;    // hand ownership to control store
        logic release_all;
    } seq_events_t;

    function automatic logic [STOP_W-1:0] stop_bit(input int pos);
        logic [STOP_W-1:0] v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/ctl_mode_flags.sv
module ctl_mode_flags
    import ctl_sv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  seq_events_t ev,
    output logic        mode_seq,
    output logic        mode_ms,
    output logic        mode_cs,
    output logic        log_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_seq <= 1'b0;
            mode_ms  <= 1'b0;
            mode_cs  <= 1'b1;
            log_flag <= 1'b0;
        end else begin
            if (ev.gate) begin
                mode_seq <= 1'b1;
                mode_ms  <= 1'b0;
                mode_cs  <= 1'b0;
            end else if (ev.to_ms) begin
                mode_seq <= 1'b0;
                mode_ms  <= 1'b1;
                mode_cs  <= 1'b0;
            end else if (ev.to_cs) begin
                mode_seq <= 1'b0;
                mode_ms  <= 1'b0;
                mode_cs  <= 1'b1;
            end
            if (ev.gate)
                log_flag <= 1'b1;
            else if (ev.release_all)
                log_flag <= 1'b0;
        end
    end

    a_r9_one_owner: assert property (@(posedge clk) disable iff (rst)
        $countones({mode_seq, mode_ms, mode_cs}) <= 1);

    a_r8_release_clears_log: assert property (@(posedge clk) disable iff (rst)
        ev.release_all |=> !log_flag && mode_cs);

endmodule

// File: rtl/ctl_stop_encoder.sv
module ctl_stop_encoder
    import ctl_sv_pkg::*;
(
    input  seq_events_t       ev,
    output logic [STOP_W-1:0] stop_set,
    output logic [STOP_W-1:0] stop_clr
);

    localparam logic [STOP_W-1:0] INTR_MASK =
        stop_bit(STOP_CPUIO) | stop_bit(STOP_CSTORE) | stop_bit(STOP_MSTORE);
    localparam logic [STOP_W-1:0] GATE_MASK = stop_bit(STOP_MSTORE);
    localparam logic [STOP_W-1:0] CSF_MASK  = stop_bit(STOP_CSTORE);

    for (genvar b = 0; b < STOP_W; b++) begin : g_bit
        assign stop_set[b] = ev.intr & INTR_MASK[b];
        assign stop_clr[b] = (ev.gate & GATE_MASK[b])
                           | (ev.cs_free & CSF_MASK[b])
                           | ev.release_all;
    end

endmodule

// File: rtl/ctl_logout_fsm.sv
module ctl_logout_fsm
    import ctl_sv_pkg::*;
#(
    parameter int SC_ITEMS  = 3,
    parameter int CS_GROUPS = 4,
    localparam int N_ITEMS  = SC_ITEMS + CS_GROUPS + 1,
    localparam int IDX_W    = $clog2(N_ITEMS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             logout_req,
    input  logic             store_done,
    output seq_events_t      ev,
    output logic             dead_cycle,
    output logic             cmd_valid,
    output logic [IDX_W-1:0] cmd_idx
);

    localparam logic [IDX_W-1:0] SC_LAST  = IDX_W'(SC_ITEMS - 1);
    localparam logic [IDX_W-1:0] ALL_LAST = IDX_W'(N_ITEMS - 1);

    seq_state_t st, st_nx;
    logic [IDX_W-1:0] idx_nx;
    logic accept;

    assign cmd_valid  = (st == SQ_SAVE_SC) || (st == SQ_SAVE_MS);
    assign accept     = cmd_valid && store_done;
    assign dead_cycle = (st == SQ_DEAD);

    always_comb begin
        ev             = '0;
        ev.intr        = (st == SQ_IDLE) && tick && logout_req;
        ev.gate        = (st == SQ_DEAD) && tick;
        ev.to_ms       = (st == SQ_TO_MS) && tick;
        ev.cs_free     = (st == SQ_SAVE_MS) && accept && (cmd_idx == ALL_LAST);
        ev.to_cs       = (st == SQ_TO_CS) && tick;
        ev.release_all = (st == SQ_RELEASE) && tick;
    end

    always_comb begin
        st_nx  = st;
        idx_nx = cmd_idx;
        unique case (st)
            SQ_IDLE:    if (ev.intr) st_nx = SQ_DEAD;
            SQ_DEAD:    if (tick) begin
                            st_nx  = SQ_SAVE_SC;
                            idx_nx = '0;
                        end
            SQ_SAVE_SC: if (accept) begin
                            idx_nx = cmd_idx + 1'b1;
                            if (cmd_idx == SC_LAST) st_nx = SQ_TO_MS;
                        end
            SQ_TO_MS:   if (tick) st_nx = SQ_SAVE_MS;
            SQ_SAVE_MS: if (accept) begin
                            if (cmd_idx == ALL_LAST) st_nx = SQ_TO_CS;
                            else idx_nx = cmd_idx + 1'b1;
                        end
            SQ_TO_CS:   if (tick) st_nx = SQ_RELEASE;
            SQ_RELEASE: if (tick) st_nx = SQ_IDLE;
            default:    st_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            cmd_idx <= '0;
        end else begin
            st      <= st_nx;
            cmd_idx <= idx_nx;
        end
    end

    a_r5_cmd_held: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !store_done |=> cmd_valid && $stable(cmd_idx));

    a_r3_single_dead: assert property (@(posedge clk) disable iff (rst)
        dead_cycle && tick |=> !dead_cycle);

endmodule

// File: rtl/ctl_mode_sequencer.sv
module ctl_mode_sequencer
    import ctl_sv_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LOG_BASE   = 80,
    parameter int WORD_BYTES = 4,
    parameter int SC_ITEMS   = 3,
    parameter int CS_GROUPS  = 4,
    localparam int N_ITEMS   = SC_ITEMS + CS_GROUPS + 1,
    localparam int IDX_W     = $clog2(N_ITEMS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              logout_req,
    input  logic              store_done,
    output logic [STOP_W-1:0] stop_set,
    output logic [STOP_W-1:0] stop_clr,
    output logic              dead_cycle,
    output logic              gate_status,
    output logic              mode_seq,
    output logic              mode_ms,
    output logic              mode_cs,
    output logic              log_flag,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [IDX_W-1:0]  cmd_src
);

    seq_events_t ev;

    ctl_logout_fsm #(
        .SC_ITEMS  (SC_ITEMS),
        .CS_GROUPS (CS_GROUPS)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .logout_req (logout_req),
        .store_done (store_done),
        .ev         (ev),
        .dead_cycle (dead_cycle),
        .cmd_valid  (cmd_valid),
        .cmd_idx    (cmd_src)
    );

    ctl_mode_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .mode_seq (mode_seq),
        .mode_ms  (mode_ms),
        .mode_cs  (mode_cs),
        .log_flag (log_flag)
    );

    ctl_stop_encoder u_stop (
        .ev       (ev),
        .stop_set (stop_set),
        .stop_clr (stop_clr)
    );

    assign gate_status = ev.gate;
    assign cmd_addr    = ADDR_W'(LOG_BASE) + ADDR_W'(cmd_src) * ADDR_W'(WORD_BYTES);

    a_r2_stop_then_dead: assert property (@(posedge clk) disable iff (rst)
        (stop_set != '0) |=> dead_cycle);

    a_r4_gate_sets_seq: assert property (@(posedge clk) disable iff (rst)
        gate_status |=> log_flag && mode_seq);

    a_r5_no_store_when_dead: assert property (@(posedge clk) disable iff (rst)
        dead_cycle |-> !cmd_valid);

endmodule

// File: tb/ctl_mode_sequencer_test.sv
`timescale 1ns/1ps
module ctl_mode_sequencer_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, logout_req = 1'b0, store_done = 1'b0;
    logic [3:0]  stop_set, stop_clr;
    logic        dead_cycle, gate_status, mode_seq, mode_ms, mode_cs, log_flag, cmd_valid;
    logic [15:0] cmd_addr;
    logic [2:0]  cmd_src;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 1'b0;

    typedef struct { logic [15:0] addr; logic [2:0] src; } item_t;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    ctl_mode_sequencer uut (
        .clk(clk), .rst(rst), .tick(tick), .logout_req(logout_req),
        .store_done(store_done), .stop_set(stop_set), .stop_clr(stop_clr),
        .dead_cycle(dead_cycle), .gate_status(gate_status), .mode_seq(mode_seq),
        .mode_ms(mode_ms), .mode_cs(mode_cs), .log_flag(log_flag),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_src(cmd_src)
    );

    task automatic chk(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic r, input logic d);
        @(posedge clk);
        #1;
        tick = t; logout_req = r; store_done = d;
        @(negedge clk);
    endtask

    // Driver: expected store order and addresses (R5)
    task automatic push_expected();
        for (int i = 0; i < 8; i++) begin
            item_t it;
            it.src  = 3'(i);
            it.addr = 16'(80 + 4 * i);
            exp_q.push_back(it);
        end
    endtask

    // Monitor: every accepted store is compared against the scoreboard
    always @(negedge clk) begin
        if (!rst && cmd_valid && store_done) begin
            if (exp_q.size() == 0) begin
                chk("R5 unexpected store", 1'b0, {13'd0, cmd_src, cmd_addr}, 32'd0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk("R5 store order", cmd_addr == e.addr && cmd_src == e.src,
                    {13'd0, cmd_src, cmd_addr}, {13'd0, e.src, e.addr});
            end
        end
    end

    task automatic run_logout(input int gap);
        push_expected();
        cyc(1, 1, 0);
        chk("R2 stop request", stop_set == 4'b0111 && !dead_cycle, {28'd0, stop_set}, 32'h7);
        for (int i = 0; i < gap; i++) begin
            cyc(0, 0, 0);
            chk("R3 dead waits tick", dead_cycle && !gate_status && mode_cs,
                {29'd0, dead_cycle, gate_status, mode_cs}, 32'b101);
        end
        cyc(1, 0, 0);
        chk("R3 gate in dead cycle", dead_cycle && gate_status && stop_clr == 4'b0100,
            {26'd0, dead_cycle, gate_status, stop_clr}, 32'h34);
        cyc(0, 1, 0);
        chk("R10 request ignored mid-logout", stop_set == 4'b0000, {28'd0, stop_set}, 32'h0);
        chk("R4 log and seq mode", log_flag && mode_seq && !mode_cs && cmd_valid && !dead_cycle,
            {27'd0, log_flag, mode_seq, mode_cs, cmd_valid, dead_cycle}, 32'b11010);
        for (int i = 0; i < 3; i++) begin
            for (int g = 0; g < gap; g++) cyc(0, 0, 0);
            cyc(0, 0, 1);
        end
        cyc(0, 0, 1);
        chk("R10 done ignored without command", !cmd_valid && mode_seq && exp_q.size() == 5,
            {30'd0, cmd_valid, mode_seq}, 32'b01);
        for (int g = 0; g < gap; g++) cyc(0, 0, 0);
        cyc(1, 0, 0);
        chk("R6 mode holds until edge", mode_seq && !mode_ms, {30'd0, mode_seq, mode_ms}, 32'b10);
        for (int i = 0; i < 5; i++) begin
            for (int g = 0; g < gap; g++) cyc(0, 0, 0);
            cyc(0, 0, 1);
            if (i == 0)
                chk("R6 main-store mode", mode_ms && !mode_seq && !mode_cs,
                    {29'd0, mode_seq, mode_ms, mode_cs}, 32'b010);
            if (i == 4)
                chk("R7 control-store stop freed", stop_clr == 4'b0010, {28'd0, stop_clr}, 32'h2);
            else
                chk("R7 no early free", stop_clr == 4'b0000, {28'd0, stop_clr}, 32'h0);
        end
        cyc(1, 0, 0);
        chk("R8 to control store", stop_clr == 4'b0000 && mode_ms, {27'd0, mode_ms, stop_clr}, 32'h10);
        cyc(0, 0, 0);
        chk("R8 control-store mode", mode_cs && !mode_ms && log_flag && stop_clr == 4'b0000,
            {26'd0, mode_cs, mode_ms, log_flag, 1'b0, stop_clr[1:0]}, 32'b101000);
        cyc(1, 0, 0);
        chk("R8 release all stops", stop_clr == 4'b1111, {28'd0, stop_clr}, 32'hf);
        cyc(0, 0, 0);
        chk("R8 log cleared", !log_flag && mode_cs && exp_q.size() == 0,
            {30'd0, log_flag, mode_cs}, 32'b01);
        chk("R9 single owner", (32'(mode_seq) + 32'(mode_ms) + 32'(mode_cs)) == 1,
            32'(mode_seq) + 32'(mode_ms) + 32'(mode_cs), 32'd1);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk("watchdog", 1'b0, 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 reset flags", mode_cs && !mode_seq && !mode_ms && !log_flag,
            {28'd0, mode_cs, mode_seq, mode_ms, log_flag}, 32'b1000);
        chk("R1 reset outputs", stop_set == 0 && stop_clr == 0 && !gate_status && !dead_cycle && !cmd_valid,
            {21'd0, stop_set, stop_clr, gate_status, dead_cycle, cmd_valid}, 32'd0);
        cyc(0, 1, 0);
        chk("R2 no tick no stop", stop_set == 4'b0000, {28'd0, stop_set}, 32'h0);
        cyc(0, 0, 1);
        chk("R2 still idle", !dead_cycle && mode_cs, {30'd0, dead_cycle, mode_cs}, 32'b01);
        run_logout(0);
        cyc(0, 0, 0);
        run_logout(2);
        repeat (2) cyc(0, 0, 0);
        finish_run();
    end

endmodule